// File: doc/BRIEF.md
# Tri-Level Return-to-Middle Serial Transmitter

This block sends one 40-bit command frame over a single wire that can sit at three voltage levels. It does not drive the pin itself. It drives a data line and an output-enable line into an external tri-state buffer. While the buffer is disabled, a resistor divider holds the pin at the middle level. The frame starts with a fixed 16-bit sync word, `0xFA0A`. An 8-bit register address follows, then a 16-bit data word. Every bit starts with a driven phase: high for a one, low for a zero. After the driven phase the line returns to the middle level.

Software, or a higher-level controller, starts a frame with a one-cycle pulse on `start`. At that pulse it supplies the address, the data word, the two phase lengths and the guard option. The lengths are counted in clock cycles. The middle phase can be made long enough for the pin's RC network to settle. The guard option adds one cycle before each driven phase. In that cycle the data line already holds the new bit while the buffer is still off, so the data line never changes in the same cycle that the enable turns on. The enable polarity is chosen by an input, so either kind of buffer can be used.

Top module: `trilevel_tx`

## Requirements
- R1: In reset and while idle, `busy` and `done` are 0, `line_data` is 0, and `line_oe` sits at its inactive level. The inactive level is 1 when `oe_active_low` is 1 and 0 when `oe_active_low` is 0.
- R2: A frame sends 40 bits in this order: the sync word `0xFA0A`, then `addr_in[7:0]`, then `data_in[15:0]`. Each field is sent most significant bit first.
- R3: For each bit there is a logic phase and then a middle phase.
  - Logic phase: lasts the latched logic length. `line_data` equals the bit value and the enable is active.
  - Middle phase: lasts the latched middle length. The enable is inactive and `line_data` keeps the bit value.
- R4: The inputs `logic_len` and `mid_len` are captured on the cycle in which `start` is accepted. A length of 0 acts as 1.
- R5: If `guard_en` is 1 when the frame is accepted, every bit begins with a one-cycle guard phase before its logic phase. During the guard phase `line_data` already equals the bit value and the enable is inactive. The guard phase repeats for every bit.
- R6: `line_oe` is the active-level enable. Its active level is 0 when `oe_active_low` is 1 and 1 when `oe_active_low` is 0.
- R7: `busy` goes high in the cycle after `start` is accepted and stays high through the last middle-phase cycle of bit 40.
  - `done` is high for exactly one cycle, the cycle after that last middle-phase cycle.
  - A frame therefore takes 40 × (G + L + M) cycles, where G is 1 with guard and 0 without, and L and M are the effective phase lengths.
- R8: A `start` pulse while `busy` is 1 has no effect. The frame in progress and its inputs are kept.
- R9: A `start` in the cycle where `done` is high is accepted, so frames can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Frame request, sampled while idle |
| addr_in | input | 8 | Register address field of the frame |
| data_in | input | 16 | Data word field of the frame |
| logic_len | input | 8 | Logic-phase length in cycles (0 acts as 1) |
| mid_len | input | 8 | Middle-phase length in cycles (0 acts as 1) |
| guard_en | input | 1 | Adds one guard cycle before each logic phase |
| oe_active_low | input | 1 | Selects the polarity of the buffer enable |
| busy | output | 1 | A frame is on the line |
| done | output | 1 | One-cycle pulse after the final middle phase |
| line_data | output | 1 | Data input of the external buffer |
| line_oe | output | 1 | Enable input of the external buffer |

## Verification
The bench builds the block with its default widths: a 16-bit sync word, an 8-bit address, 16-bit data, 8-bit lengths and guard support enabled. With these values the real 40-bit frame layout is exercised. The length inputs can take both 0 and values of several cycles, so both the minimum-length case and stretched phases are covered. The bench runs frames with both enable polarities and with the guard cycle turned on and off. It also issues a start request in the middle of a frame, which must be ignored, and a start request on the same cycle as `done`, which must be accepted.

// File: rtl/tl_pkg.sv
package tl_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_GUARD = 2'd1,
      PH_LOGIC = 2'd2,
      PH_MID   = 2'd3
   } tl_phase_e;
endpackage

// File: rtl/tl_phase_timer.sv
// Down counter that times one phase; a loaded length of 0 or 1 expires at once
module tl_phase_timer #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] load_len,
   output logic             expired
);
   logic [LEN_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= (load_len == '0) ? '0 : load_len - LEN_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - LEN_W'(1);
      end
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/tl_frame_shifter.sv
// Frame shift register; the top bit is the bit currently on the line
module tl_frame_shifter #(
   parameter int FRAME_W = 40
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               shift,
   input  logic [FRAME_W-1:0] load_val,
   output logic               msb
);
   logic [FRAME_W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (load) begin
         sr_q <= load_val;
      end else if (shift) begin
         sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
      end
   end

   assign msb = sr_q[FRAME_W-1];
endmodule

// File: rtl/trilevel_tx.sv
module trilevel_tx
   import tl_pkg::*;
#(
   parameter int               SYNC_W        = 16,
   parameter logic [SYNC_W-1:0] SYNC_WORD    = 16'hFA0A,
   parameter int               ADDR_W        = 8,
   parameter int               DATA_W        = 16,
   parameter int               LEN_W         = 8,
   parameter bit               GUARD_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   input  logic [LEN_W-1:0]  logic_len,
   input  logic [LEN_W-1:0]  mid_len,
   input  logic              guard_en,
   input  logic              oe_active_low,
   output logic              busy,
   output logic              done,
   output logic              line_data,
   output logic              line_oe
);
   localparam int FRAME_W = SYNC_W + ADDR_W + DATA_W;
   localparam int IDX_W   = $clog2(FRAME_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

   // elaboration-time parameter checks
   if (SYNC_W < 1 || ADDR_W < 1 || DATA_W < 1) begin : g_bad_fields
      $error("trilevel_tx: every frame field needs at least one bit");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("trilevel_tx: LEN_W must be at least 1");
   end

   tl_phase_e        phase_q, phase_d;
   logic [IDX_W-1:0] bit_q;
   logic [LEN_W-1:0] logic_len_q, mid_len_q;
   logic             guard_q, done_q;
   logic             tmr_load, tmr_expired;
   logic [LEN_W-1:0] tmr_len;
   logic             sr_load, sr_shift, sr_msb;
   logic             accept, last_bit_end, guard_req;

   // generate picks whether the guard-cycle option exists at all
   if (GUARD_SUPPORT) begin : g_guard
      assign guard_req = guard_en;
   end else begin : g_no_guard
      logic unused_guard;
      assign unused_guard = guard_en;
      assign guard_req    = 1'b0;
   end

   assign accept       = (phase_q == PH_IDLE) && start;
   assign last_bit_end = (phase_q == PH_MID) && tmr_expired && (bit_q == LAST_IDX);

   always_comb begin
      phase_d  = phase_q;
      tmr_load = 1'b0;
      tmr_len  = '0;
      sr_load  = 1'b0;
      sr_shift = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (start) begin
               sr_load  = 1'b1;
               tmr_load = 1'b1;
               phase_d  = guard_req ? PH_GUARD : PH_LOGIC;
               tmr_len  = guard_req ? LEN_W'(1) : logic_len;
            end
         end
         PH_GUARD: begin
            if (tmr_expired) begin
               phase_d  = PH_LOGIC;
               tmr_load = 1'b1;
               tmr_len  = logic_len_q;
            end
         end
         PH_LOGIC: begin
            if (tmr_expired) begin
               phase_d  = PH_MID;
               tmr_load = 1'b1;
               tmr_len  = mid_len_q;
            end
         end
         PH_MID: begin
            if (tmr_expired) begin
               if (bit_q == LAST_IDX) begin
                  phase_d = PH_IDLE;
               end else begin
                  sr_shift = 1'b1;
                  tmr_load = 1'b1;
                  phase_d  = guard_q ? PH_GUARD : PH_LOGIC;
                  tmr_len  = guard_q ? LEN_W'(1) : logic_len_q;
               end
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         bit_q       <= '0;
         logic_len_q <= '0;
         mid_len_q   <= '0;
         guard_q     <= 1'b0;
         done_q      <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done_q  <= last_bit_end;
         if (accept) begin
            bit_q       <= '0;
            logic_len_q <= logic_len;
            mid_len_q   <= mid_len;
            guard_q     <= guard_req;
         end else if (sr_shift) begin
            bit_q <= bit_q + IDX_W'(1);
         end
      end
   end

   tl_phase_timer #(.LEN_W(LEN_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_len (tmr_len),
      .expired  (tmr_expired)
   );

   tl_frame_shifter #(.FRAME_W(FRAME_W)) u_shifter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sr_load),
      .shift    (sr_shift),
      .load_val ({SYNC_WORD, addr_in, data_in}),
      .msb      (sr_msb)
   );

   assign busy      = (phase_q != PH_IDLE);
   assign done      = done_q;
   assign line_data = busy & sr_msb;
   assign line_oe   = (phase_q == PH_LOGIC) ^ oe_active_low;
endmodule

// File: rtl/tl_tx_checker.sv
module tl_tx_checker (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic line_data,
   input logic line_oe,
   input logic oe_active_low,
   input logic guard_q
);
   logic drive_on;
   assign drive_on = line_oe ^ oe_active_low;

   // R7: done lasts a single cycle
   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: done only follows the end of a busy stretch
   assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

   // R1: the line is released whenever no frame is running
   assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !drive_on);

   // R3: data does not move while the line is driven
   assert_data_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_on && $past(drive_on) && $stable(oe_active_low)) |-> $stable(line_data));

   // R5: in guard mode the data is already settled when the enable turns on
   assert_guard_settled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(drive_on) && guard_q && $stable(oe_active_low)) |-> $stable(line_data));
endmodule

bind trilevel_tx tl_tx_checker u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .busy          (busy),
   .done          (done),
   .line_data     (line_data),
   .line_oe       (line_oe),
   .oe_active_low (oe_active_low),
   .guard_q       (guard_q)
);

// File: tb/trilevel_tx_bench.sv
`timescale 1ns/1ps
module trilevel_tx_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  addr_in = '0;
   logic [15:0] data_in = '0;
   logic [7:0]  logic_len = '0;
   logic [7:0]  mid_len = '0;
   logic        guard_en = 1'b0;
   logic        oe_active_low = 1'b0;
   logic        busy, done, line_data, line_oe;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   always #10 clk = ~clk;   // 50 MHz

   trilevel_tx u_trilevel_tx (
      .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in),
      .data_in(data_in), .logic_len(logic_len), .mid_len(mid_len),
      .guard_en(guard_en), .oe_active_low(oe_active_low),
      .busy(busy), .done(done), .line_data(line_data), .line_oe(line_oe)
   );

   // reference model: one entry per cycle, {busy, done, data, drive}
   logic [3:0] q[$];
   logic [3:0] cur = 4'b0000;

   function automatic void build_frame(logic [7:0] a, logic [15:0] d,
                                       logic [7:0] l, logic [7:0] m, logic g);
      logic [39:0] fr = {16'hFA0A, a, d};
      int ln = (l == 0) ? 1 : int'(l);   // R4: zero acts as one
      int mn = (m == 0) ? 1 : int'(m);
      for (int b = 39; b >= 0; b--) begin
         if (g) q.push_back({1'b1, 1'b0, fr[b], 1'b0});          // R5 guard cycle
         for (int k = 0; k < ln; k++) q.push_back({1'b1, 1'b0, fr[b], 1'b1});
         for (int k = 0; k < mn; k++) q.push_back({1'b1, 1'b0, fr[b], 1'b0});
      end
      q.push_back(4'b0100);                                     // R7 done cycle
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q.delete();
         cur = 4'b0000;
      end else begin
         if (start && !cur[3]) begin      // R8: ignored while busy, R9: accepted on done
            q.delete();
            build_frame(addr_in, data_in, logic_len, mid_len, guard_en);
         end
         if (q.size() > 0) cur = q.pop_front();
         else cur = 4'b0000;
      end
   end

   task automatic chk(string req, logic act, logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      chk("R7 busy", busy, cur[3]);
      chk("R7 done", done, cur[2]);
      chk("R2 R3 line_data", line_data, cur[1]);
      chk("R3 R6 line_oe", line_oe, cur[0] ^ oe_active_low);
   end

   task automatic send(logic [7:0] a, logic [15:0] d, logic [7:0] l,
                       logic [7:0] m, logic g);
      addr_in = a; data_in = d; logic_len = l; mid_len = m; guard_en = g;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      while (done !== 1'b1) @(negedge clk);
   endtask

   initial begin
      fork
         begin : watchdog
            repeat (150000) @(posedge clk);
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      join_none
      // R1: reset state under both polarities
      repeat (3) @(negedge clk);
      oe_active_low = 1'b1;
      @(negedge clk);
      chk("R1 reset oe", line_oe, 1'b1);
      oe_active_low = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      // R2 R3: plain frame, active-high enable
      send(8'h06, 16'h139F, 8'd3, 8'd2, 1'b0);
      repeat (50) @(negedge clk);
      // R8: request while busy must change nothing
      send(8'hFF, 16'hFFFF, 8'd1, 8'd1, 1'b1);
      wait_done();
      @(negedge clk);
      // R4 R5 R6: zero lengths, guard cycle, active-low enable
      oe_active_low = 1'b1;
      @(negedge clk);
      send(8'h07, 16'h000A, 8'd0, 8'd0, 1'b1);
      wait_done();
      // R9: new request on the done cycle
      send(8'h5A, 16'hBD98, 8'd1, 8'd4, 1'b1);
      wait_done();
      oe_active_low = 1'b0;
      send(8'hA5, 16'h0001, 8'd2, 8'd1, 1'b0);
      wait_done();
      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule